// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block sits beside a general-purpose timer and turns its event pulses into sticky status flags and a single interrupt request. It watches six event sources: an external trigger line, the update event, and one capture/compare event for each of four channels. Each source sets its own flag, and the flag stays set until software clears it. A per-flag enable mask chooses which flags may raise the request. A global enable gates the request and is controlled through separate set and clear registers. A missed-event register records any channel event that arrives while that channel's flag is still pending.

Software uses a small register bus with write and read strobes, an address and data. Flags and missed bits are cleared by writing 1 to them. A channel in capture mode also clears its flag when software reads its capture value. The external trigger is asynchronous. It passes through a two-flop synchroniser and then a two-state edge tracker. The tracker's states are TRG_LOW and TRG_HIGH. The RISE transition (TRG_LOW to TRG_HIGH) always produces a trigger event. The FALL transition (TRG_HIGH to TRG_LOW) produces one only in gated mode.

Register map (4-bit address, bus data 16 bits by default):

- 0x0 status: bit 0 is the trigger flag, bit 1 is the update flag, and bit 2+c is the flag of channel c. Writing 1 to a bit clears it.
- 0x1 mask: read/write, all bits stored. Bit k enables status bit k.
- 0x2 missed: bit c belongs to channel c. Writing 1 to a bit clears it.
- 0x3 enable-set and 0x4 enable-clear: bit 0 acts on the global enable, and both addresses read the enable back in bit 0.
- 0x8+c: capture value of channel c.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, status, missed, mask and global enable all read 0, and the interrupt output is low.
- R2: Writing 1 in bit 0 to address 0x3 sets the global enable, and writing 1 in bit 0 to address 0x4 clears it. Writing 0 to either address leaves the enable unchanged.
- R3: An update pulse sets status bit 1, and a pulse on channel c sets status bit 2+c. Flags remain set while no clear source acts on them.
- R4: With gated mode off, a rising edge of the external trigger sets status bit 0 and a falling edge does not. With gated mode on, either edge sets it.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: When channel c is in capture mode (mode bit 1), a read strobe at address 0x8+c returns that channel's value and clears status bit 2+c. In compare mode (mode bit 0) the same read leaves the flag set.
- R8: The interrupt output is registered. One clock after the state changes, it equals the global enable ANDed with the OR over k of (status bit k AND mask bit k).
- R9: A channel event that arrives while the channel's flag is already set sets missed bit c. Writing 1 to a missed bit clears it, and writing 0 leaves it unchanged.
- R10: The trigger passes through two synchronising flops. An edge applied between clocks shows in status bit 0 after the third following rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe (drives read side effects) |
| addr_i | input | 4 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| gated_mode_i | input | 1 | 1: both trigger edges count |
| upd_ev_i | input | 1 | Update event pulse |
| cc_ev_i | input | NUM_CH | Capture/compare event pulse per channel |
| cc_capture_i | input | NUM_CH | Per channel: 1 capture mode, 0 compare mode |
| cc_value_i | input | NUM_CH*VAL_W | Capture values, channel c at bits c*VAL_W upward |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle, inside the logic they guard:

- Flags stay set unless a clear source acts on them.
- An event always wins over a same-cycle clear.
- A repeated channel event always lands in the missed register.
- A cleared enable or an empty masked set always forces the request low on the next cycle.
- The enable strobes act on the following cycle.
- A capture-mode read clears its flag.
- No falling trigger edge produces an event outside gated mode.

Other behaviour can only be shown by the bench's scenarios:

- The exact OR-of-masked-flags value across every mask and flag combination.
- The three-edge latency of the trigger synchroniser.
- That compare-mode reads and zero writes change nothing.
- The values returned on capture reads.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_STATUS  = 4'h0;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'h1;
    localparam logic [ADDR_W-1:0] A_MISS    = 4'h2;
    localparam logic [ADDR_W-1:0] A_GEN_SET = 4'h3;
    localparam logic [ADDR_W-1:0] A_GEN_CLR = 4'h4;
    localparam int CAP_BASE = 8;

    localparam int F_TRIG = 0;
    localparam int F_UPD  = 1;
    localparam int F_CC0  = 2;

    typedef enum logic {
        TRG_LOW  = 1'b0,
        TRG_HIGH = 1'b1
    } trg_state_e;
endpackage

// File: rtl/tmr_trig_fsm.sv
module tmr_trig_fsm
    import tmr_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    input  logic gated_i,
    output logic trig_ev_o
);
    logic       sync1_q;
    logic       sync2_q;
    trg_state_e state_q;
    trg_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= trig_i;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TRG_LOW;
        else         state_q <= state_d;
    end

    // next state: RISE and FALL transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_LOW:  if (sync2_q)  state_d = TRG_HIGH;
            TRG_HIGH: if (!sync2_q) state_d = TRG_LOW;
            default:  state_d = TRG_LOW;
        endcase
    end

    // outputs
    always_comb begin
        trig_ev_o = 1'b0;
        unique case (state_q)
            TRG_LOW:  trig_ev_o = sync2_q;
            TRG_HIGH: trig_ev_o = !sync2_q && gated_i;
            default:  trig_ev_o = 1'b0;
        endcase
    end

    a_r4_fall_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gated_i && state_q == TRG_HIGH) |-> !trig_ev_o);

    a_r10_rise_tracked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == TRG_LOW && sync2_q) |=> (state_q == TRG_HIGH));
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
    parameter int NUM_CH = 4,
    localparam int NF = NUM_CH + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_ev_i,
    input  logic              upd_ev_i,
    input  logic [NUM_CH-1:0] cc_ev_i,
    input  logic [NF-1:0]     w1c_flags_i,
    input  logic [NUM_CH-1:0] rdclr_cc_i,
    input  logic [NUM_CH-1:0] w1c_miss_i,
    output logic [NF-1:0]     flags_o,
    output logic [NUM_CH-1:0] miss_o
);
    logic [NF-1:0]     set_vec;
    logic [NF-1:0]     clr_vec;
    logic [NF-1:0]     flags_q;
    logic [NUM_CH-1:0] miss_q;
    logic [NUM_CH-1:0] miss_hit;

    assign set_vec  = {cc_ev_i, upd_ev_i, trig_ev_i};
    assign clr_vec  = w1c_flags_i | {rdclr_cc_i, 2'b00};
    assign miss_hit = cc_ev_i & flags_q[NF-1:2];

    for (genvar k = 0; k < NF; k++) begin : g_flag
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          flags_q[k] <= 1'b0;
            else if (set_vec[k])  flags_q[k] <= 1'b1;
            else if (clr_vec[k])  flags_q[k] <= 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_miss
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            miss_q[c] <= 1'b0;
            else if (miss_hit[c])   miss_q[c] <= 1'b1;
            else if (w1c_miss_i[c]) miss_q[c] <= 1'b0;
        end
    end

    assign flags_o = flags_q;
    assign miss_o  = miss_q;

    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_vec)) == $past(flags_q & ~clr_vec)));

    a_r6_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

    a_r9_missed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cc_ev_i & flags_q[NF-1:2]) != '0) |=>
        ((miss_q & $past(cc_ev_i & flags_q[NF-1:2])) == $past(cc_ev_i & flags_q[NF-1:2])));
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out #(
    parameter int NF = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NF-1:0] flags_i,
    input  logic [NF-1:0] mask_i,
    input  logic          en_i,
    output logic          irq_o
);
    logic irq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= en_i && ((flags_i & mask_i) != '0);
    end

    assign irq_o = irq_q;

    a_r8_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !irq_o);

    a_r8_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int VAL_W  = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    input  logic                    ext_trig_i,
    input  logic                    gated_mode_i,
    input  logic                    upd_ev_i,
    input  logic [NUM_CH-1:0]       cc_ev_i,
    input  logic [NUM_CH-1:0]       cc_capture_i,
    input  logic [NUM_CH*VAL_W-1:0] cc_value_i,
    output logic                    irq_o
);
    localparam int NF = NUM_CH + 2;

    logic              sel_status, sel_mask, sel_miss, sel_set, sel_clr;
    logic [NUM_CH-1:0] cap_hit;
    logic [NUM_CH-1:0] rdclr_cc;
    logic [NF-1:0]     w1c_flags;
    logic [NUM_CH-1:0] w1c_miss;
    logic [NF-1:0]     flags;
    logic [NUM_CH-1:0] miss;
    logic [DATA_W-1:0] mask_q;
    logic              gen_en_q;
    logic              trig_ev;

    assign sel_status = (addr_i == A_STATUS);
    assign sel_mask   = (addr_i == A_MASK);
    assign sel_miss   = (addr_i == A_MISS);
    assign sel_set    = (addr_i == A_GEN_SET);
    assign sel_clr    = (addr_i == A_GEN_CLR);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
        localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_BASE + c);
        assign cap_hit[c]  = (addr_i == CAP_A);
        assign rdclr_cc[c] = rd_en_i && cap_hit[c] && cc_capture_i[c];

        a_r7_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_en_i && cap_hit[c] && cc_capture_i[c] && !cc_ev_i[c]) |=> !flags[F_CC0 + c]);
    end

    assign w1c_flags = (wr_en_i && sel_status) ? wdata_i[NF-1:0] : '0;
    assign w1c_miss  = (wr_en_i && sel_miss) ? wdata_i[NUM_CH-1:0] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  mask_q <= '0;
        else if (wr_en_i && sel_mask) mask_q <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              gen_en_q <= 1'b0;
        else if (wr_en_i && sel_set && wdata_i[0]) gen_en_q <= 1'b1;
        else if (wr_en_i && sel_clr && wdata_i[0]) gen_en_q <= 1'b0;
    end

    a_r2_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel_set && wdata_i[0]) |=> gen_en_q);

    a_r2_enable_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel_clr && wdata_i[0]) |=> !gen_en_q);

    always_comb begin
        rdata_o = '0;
        if (sel_status)          rdata_o[NF-1:0] = flags;
        else if (sel_mask)       rdata_o = mask_q;
        else if (sel_miss)       rdata_o[NUM_CH-1:0] = miss;
        else if (sel_set || sel_clr) rdata_o[0] = gen_en_q;
        else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (cap_hit[c]) rdata_o[VAL_W-1:0] = cc_value_i[c*VAL_W +: VAL_W];
            end
        end
    end

    tmr_trig_fsm u_trig (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (ext_trig_i),
        .gated_i   (gated_mode_i),
        .trig_ev_o (trig_ev)
    );

    tmr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trig_ev_i   (trig_ev),
        .upd_ev_i    (upd_ev_i),
        .cc_ev_i     (cc_ev_i),
        .w1c_flags_i (w1c_flags),
        .rdclr_cc_i  (rdclr_cc),
        .w1c_miss_i  (w1c_miss),
        .flags_o     (flags),
        .miss_o      (miss)
    );

    tmr_irq_out #(.NF(NF)) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flags_i (flags),
        .mask_i  (mask_q[NF-1:0]),
        .en_i    (gen_en_q),
        .irq_o   (irq_o)
    );
endmodule

// File: tb/tmr_irq_flags_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int VW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ext_trig = 1'b0, gated = 1'b0, upd_ev = 1'b0;
    logic [NCH-1:0] cc_ev = '0, cc_cap = '0;
    logic [NCH*VW-1:0] cc_val = {16'hD3D3, 16'hC2C2, 16'hB1B1, 16'hA0A0};
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] d;

    always #2 clk = ~clk;

    tmr_irq_flags #(.NUM_CH(NCH), .DATA_W(DW), .VAL_W(VW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .ext_trig_i(ext_trig), .gated_mode_i(gated), .upd_ev_i(upd_ev),
        .cc_ev_i(cc_ev), .cc_capture_i(cc_cap), .cc_value_i(cc_val), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [DW-1:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic pulse(input logic u, input logic [NCH-1:0] c);
        @(negedge clk); upd_ev = u; cc_ev = c;
        @(negedge clk); upd_ev = 1'b0; cc_ev = '0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(4'h0, d); chk("R1 status", d, 0);
        peek(4'h1, d); chk("R1 mask", d, 0);
        peek(4'h2, d); chk("R1 missed", d, 0);
        peek(4'h3, d); chk("R1 enable", d, 0);
        chk("R1 irq", irq, 0);

        // R2 global enable strobes
        wr(4'h3, 16'h0); peek(4'h3, d); chk("R2 set with 0", d, 0);
        wr(4'h3, 16'h1); peek(4'h3, d); chk("R2 set", d, 1);
        wr(4'h4, 16'hFFFE); peek(4'h4, d); chk("R2 clear with 0 in bit0", d, 1);
        wr(4'h4, 16'h1); peek(4'h3, d); chk("R2 clear", d, 0);

        // R8 registered irq latency, R3 update flag
        wr(4'h1, 16'h0002); wr(4'h3, 16'h1);
        pulse(1'b1, '0);
        peek(4'h0, d); chk("R3 update flag", d, 16'h0002);
        chk("R8 irq one clock late", irq, 0);
        @(negedge clk); chk("R8 irq after one clock", irq, 1);
        wait_n(3); peek(4'h0, d); chk("R3 sticky", d, 16'h0002);

        // R5 W1C
        wr(4'h0, 16'h0); peek(4'h0, d); chk("R5 write 0 keeps", d, 16'h0002);
        wr(4'h0, 16'h0002); peek(4'h0, d); chk("R5 write 1 clears", d, 0);
        @(negedge clk); chk("R8 irq drops", irq, 0);

        // R8 / R3 sweep over mask and event patterns (trigger excluded)
        for (int m = 0; m < 64; m++) begin
            for (int p = 0; p < 32; p++) begin
                logic [5:0] fl;
                fl = 6'(p << 1);
                wr(4'h1, 16'(m));
                wr(4'h0, 16'h003F);
                pulse(p[0], p[4:1]);
                @(negedge clk);
                peek(4'h0, d); chk("R3 sweep status", d, 16'(fl));
                chk("R8 sweep irq", irq, ((fl & 6'(m)) != 0) ? 1 : 0);
            end
        end
        wr(4'h4, 16'h1); wr(4'h1, 16'h003F); pulse(1'b1, 4'hF);
        @(negedge clk); chk("R8 enable off", irq, 0);
        wr(4'h0, 16'h003F); wr(4'h2, 16'h000F);

        // R10 / R4 trigger
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); @(negedge clk);
        peek(4'h0, d); chk("R10 not after two edges", d, 0);
        @(negedge clk);
        peek(4'h0, d); chk("R10 set after three edges", d, 1);
        wr(4'h0, 16'h1);
        @(negedge clk); ext_trig = 1'b0; wait_n(5);
        peek(4'h0, d); chk("R4 fall ignored ungated", d, 0);
        gated = 1'b1;
        @(negedge clk); ext_trig = 1'b1; wait_n(5);
        peek(4'h0, d); chk("R4 rise gated", d, 1);
        wr(4'h0, 16'h1);
        @(negedge clk); ext_trig = 1'b0; wait_n(5);
        peek(4'h0, d); chk("R4 fall gated", d, 1);
        wr(4'h0, 16'h1); gated = 1'b0;

        // R7 capture read clear
        cc_cap = 4'b0100;
        pulse(1'b0, 4'b1100);
        rd(4'hA, d); chk("R7 ch2 value", d, 16'hC2C2);
        peek(4'h0, d); chk("R7 capture read clears", d, 16'h0020);
        rd(4'hB, d); chk("R7 ch3 value", d, 16'hD3D3);
        peek(4'h0, d); chk("R7 compare read keeps", d, 16'h0020);
        wr(4'h0, 16'h003F); wr(4'h2, 16'h000F);

        // R9 missed
        pulse(1'b0, 4'b0001);
        pulse(1'b0, 4'b0011);
        peek(4'h2, d); chk("R9 missed ch0 only", d, 16'h0001);
        wr(4'h2, 16'h0); peek(4'h2, d); chk("R9 write 0 keeps", d, 16'h0001);
        wr(4'h2, 16'h1); peek(4'h2, d); chk("R9 write 1 clears", d, 0);

        // R6 event wins over clear (flags: cc0, cc1, cc3 set)
        pulse(1'b0, 4'b1000);
        @(negedge clk); wr_en = 1'b1; addr = 4'h0; wdata = 16'hFFFF;
        upd_ev = 1'b1; cc_ev = 4'b0001;
        @(negedge clk); wr_en = 1'b0; upd_ev = 1'b0; cc_ev = '0;
        peek(4'h0, d); chk("R6 event beats clear", d, 16'h0006);
        peek(4'h2, d); chk("R9 miss on pending flag", d, 16'h0001);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule